// File: doc/BRIEF.md
# FSK Proximity Tag ID Demodulator

This block turns a stream of 8-bit ADC samples of a low-frequency reader field into the 44-bit identifier that a frequency-shift-keyed proximity tag transmits. Each accepted sample is cut to one bit against a fixed level. The block measures the spacing between rising edges of that bit and labels each spacing as a fast cycle (fc/8) or a slow cycle (fc/10). Consecutive cycles of the same kind are counted and rounded into Manchester half-bits.

A frame decoder searches the half-bit stream for the start-of-frame marker. It then decodes half-bit pairs into ID bits and shifts them into an ID register, MSB first. A finished ID comes out with a one-cycle valid pulse when the following marker arrives. The block sits directly behind the sample capture path. It needs no configuration: a sample counts only in a cycle where its qualifier is high.

Top module: `fsk_id_demod`

## Requirements
- R1: A sample with a value below 127 is read as bit 0. A sample of 127 or above is read as bit 1.
- R2: Decoding starts at the first low-to-high change of the sliced bit. Samples received before that change produce no half-bits and no ID.
- R3: The sample count between two rising edges is a fast cycle (fc/8) when it is below 9 and a slow cycle (fc/10) when it is 9 or more. Small jitter, such as 7 or 8 for fast and 9 to 11 for slow, decodes the same as exact 8 and 10.
- R4: A run of n cycles of one kind ends when the other kind appears. It yields (n+1)/6 half-bits for a fast run and (n+1)/5 for a slow run, using integer division. A fast half-bit has value 1 and a slow half-bit has value 0. Only counts from 1 to 4 are emitted. A lone fast cycle between slow runs is therefore dropped, and a 1-bit followed by a marker forms a run of four 1 half-bits.
- R5: The half-bit sequence 1,1,1,0,0,0 (oldest first) is the start-of-frame marker. After it, the pair 1,0 decodes to bit 0 and the pair 0,1 decodes to bit 1. Each decoded bit is shifted into the LSB of the 44-bit ID, so the first bit sent ends up as the MSB.
- R6: When a marker is found during a frame, the ID collected so far is driven on `id_value` and `id_valid` is high for exactly one cycle. The ID register is then cleared for the next frame.
- R7: An ID whose value is zero when the next marker arrives is not reported.
- R8: A pair of 0,0 or 1,1 during a frame discards that frame. The frame is not reported, and decoding resumes at the next marker.
- R9: Cycles with `smp_valid` low have no effect on the decoded result, whatever `smp_data` holds.
- R10: After reset, `id_valid` is 0 and `id_value` is 0. `id_value` holds the last reported ID until the next report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Qualifies `smp_data` in this cycle |
| smp_data | input | 8 | ADC sample of the reader field |
| id_valid | output | 1 | One-cycle pulse when a new ID is reported |
| id_value | output | 44 | Most recently reported tag ID |

## Verification
The assertions check on every cycle that:
- a report always carries a nonzero ID;
- the report pulse never lasts two cycles;
- the ID output stays unchanged between reports;
- every half-bit group handed to the frame decoder holds one to four half-bits;
- no cycle classification appears without a qualified sample one cycle earlier.

Only the bench scenarios can show that the IDs are correct. They cover the slicing edge at 126 and 127, period jitter, gaps in the sample stream, leading junk, zero IDs, and a frame corrupted by an invalid pair, with each result compared against the encoded frames.

// File: rtl/fskd_pkg.sv
package fskd_pkg;
   // frame decoder search state
   typedef enum logic {
      DEC_HUNT  = 1'b0,
      DEC_FRAME = 1'b1
   } dec_mode_e;

   // half-bit window used for marker search and pair decoding
   localparam int          WIN_W   = 6;
   localparam int          FILL_W  = 3;
   // oldest half-bit sits in the MSB of the window
   localparam logic [5:0]  SOF_PAT = 6'b111000;
endpackage

// File: rtl/fskd_edge_period.sv
module fskd_edge_period #(
   parameter int SMP_W     = 8,
   parameter int SLICE_LVL = 127,
   parameter int CNT_W     = 8,
   parameter int FUZZ_LIM  = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   output logic             cls_vld,
   output logic             cls_fast
);
   localparam logic [SMP_W-1:0] LVL    = SMP_W'(SLICE_LVL);
   localparam logic [CNT_W-1:0] LIM    = CNT_W'(FUZZ_LIM);
   localparam logic [CNT_W-1:0] CNT_MX = {CNT_W{1'b1}};

   logic             cur_bit;
   logic             prev_bit;
   logic             have_prev;
   logic             locked;
   logic             rise;
   logic [CNT_W-1:0] span_cnt;

   assign cur_bit = (smp_data >= LVL);
   assign rise    = have_prev && !prev_bit && cur_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_bit  <= 1'b0;
         have_prev <= 1'b0;
         locked    <= 1'b0;
         span_cnt  <= '0;
         cls_vld   <= 1'b0;
         cls_fast  <= 1'b0;
      end else begin
         cls_vld <= 1'b0;
         if (smp_valid) begin
            prev_bit  <= cur_bit;
            have_prev <= 1'b1;
            if (rise) begin
               locked   <= 1'b1;
               span_cnt <= CNT_W'(1);
               if (locked) begin
                  cls_vld  <= 1'b1;
                  cls_fast <= (span_cnt < LIM);
               end
            end else if (span_cnt != CNT_MX) begin
               span_cnt <= span_cnt + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/fskd_run_group.sv
module fskd_run_group #(
   parameter int RUN_W     = 6,
   parameter int FAST_HB   = 6,
   parameter int SLOW_HB   = 5,
   parameter int MAX_GROUP = 4,
   parameter int GRP_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cls_vld,
   input  logic             cls_fast,
   output logic             hb_vld,
   output logic [GRP_W-1:0] hb_cnt,
   output logic             hb_val
);
   localparam int          SUM_W  = RUN_W + 1;
   localparam logic [RUN_W-1:0] RUN_MX = {RUN_W{1'b1}};

   logic             run_act;
   logic             run_val;
   logic [RUN_W-1:0] run_len;
   logic [SUM_W-1:0] run_sum;
   logic [SUM_W-1:0] hb_num;
   logic             hb_ok;

   assign run_sum = {1'b0, run_len} + SUM_W'(1);

   // divisor per class: constant divide when equal, else select
   generate
      if (FAST_HB == SLOW_HB) begin : g_same_div
         assign hb_num = run_sum / SUM_W'(FAST_HB);
      end else begin : g_split_div
         logic [SUM_W-1:0] num_fast;
         logic [SUM_W-1:0] num_slow;
         assign num_fast = run_sum / SUM_W'(FAST_HB);
         assign num_slow = run_sum / SUM_W'(SLOW_HB);
         assign hb_num   = run_val ? num_fast : num_slow;
      end
   endgenerate

   assign hb_ok = (hb_num != '0) && (hb_num <= SUM_W'(MAX_GROUP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_act <= 1'b0;
         run_val <= 1'b0;
         run_len <= '0;
         hb_vld  <= 1'b0;
         hb_cnt  <= '0;
         hb_val  <= 1'b0;
      end else begin
         hb_vld <= 1'b0;
         if (cls_vld) begin
            if (!run_act) begin
               run_act <= 1'b1;
               run_val <= cls_fast;
               run_len <= RUN_W'(1);
            end else if (cls_fast == run_val) begin
               if (run_len != RUN_MX) run_len <= run_len + RUN_W'(1);
            end else begin
               hb_vld  <= hb_ok;
               hb_cnt  <= hb_num[GRP_W-1:0];
               hb_val  <= run_val;
               run_val <= cls_fast;
               run_len <= RUN_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/fskd_hb_step.sv
module fskd_hb_step
   import fskd_pkg::*;
#(
   parameter int ID_W = 44
) (
   input  logic              en,
   input  logic              hb,
   input  dec_mode_e         mode_i,
   input  logic [FILL_W-1:0] fill_i,
   input  logic [WIN_W-1:0]  win_i,
   input  logic [ID_W-1:0]   id_i,
   output dec_mode_e         mode_o,
   output logic [FILL_W-1:0] fill_o,
   output logic [WIN_W-1:0]  win_o,
   output logic [ID_W-1:0]   id_o,
   output logic              rep_o,
   output logic [ID_W-1:0]   rep_id_o
);
   localparam logic [FILL_W-1:0] FULL = FILL_W'(WIN_W);

   logic [WIN_W-1:0]  w_nx;
   logic [FILL_W-1:0] f_nx;

   assign w_nx = {win_i[WIN_W-2:0], hb};
   assign f_nx = (fill_i >= FULL) ? FULL : fill_i + FILL_W'(1);

   always_comb begin
      mode_o   = mode_i;
      fill_o   = fill_i;
      win_o    = win_i;
      id_o     = id_i;
      rep_o    = 1'b0;
      rep_id_o = id_i;
      if (en) begin
         win_o  = w_nx;
         fill_o = f_nx;
         if (mode_i == DEC_HUNT) begin
            if (f_nx == FULL && w_nx == SOF_PAT) begin
               mode_o = DEC_FRAME;
               fill_o = '0;
               id_o   = '0;
            end
         end else if (f_nx == FULL) begin
            if (w_nx == SOF_PAT) begin
               rep_o  = (id_i != '0);
               fill_o = '0;
               id_o   = '0;
            end else if (w_nx[WIN_W-1:WIN_W-2] == 2'b10) begin
               id_o   = {id_i[ID_W-2:0], 1'b0};
               fill_o = FILL_W'(WIN_W - 2);
            end else if (w_nx[WIN_W-1:WIN_W-2] == 2'b01) begin
               id_o   = {id_i[ID_W-2:0], 1'b1};
               fill_o = FILL_W'(WIN_W - 2);
            end else begin
               mode_o = DEC_HUNT;
               id_o   = '0;
            end
         end
      end
   end
endmodule

// File: rtl/fskd_frame_dec.sv
module fskd_frame_dec
   import fskd_pkg::*;
#(
   parameter int ID_W      = 44,
   parameter int MAX_GROUP = 4,
   parameter int GRP_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hb_vld,
   input  logic [GRP_W-1:0] hb_cnt,
   input  logic             hb_val,
   output logic             id_valid,
   output logic [ID_W-1:0]  id_value
);
   dec_mode_e         mode_q;
   logic [FILL_W-1:0] fill_q;
   logic [WIN_W-1:0]  win_q;
   logic [ID_W-1:0]   id_q;

   dec_mode_e         m_c  [0:MAX_GROUP];
   logic [FILL_W-1:0] f_c  [0:MAX_GROUP];
   logic [WIN_W-1:0]  w_c  [0:MAX_GROUP];
   logic [ID_W-1:0]   i_c  [0:MAX_GROUP];
   logic              r_c  [0:MAX_GROUP-1];
   logic [ID_W-1:0]   ri_c [0:MAX_GROUP-1];

   logic              rep_any;
   logic [ID_W-1:0]   rep_id;

   assign m_c[0] = mode_q;
   assign f_c[0] = fill_q;
   assign w_c[0] = win_q;
   assign i_c[0] = id_q;

   // one step per half-bit of the group, chained in order
   generate
      for (genvar g = 0; g < MAX_GROUP; g++) begin : g_step
         fskd_hb_step #(.ID_W(ID_W)) step_i (
            .en       (hb_vld && (GRP_W'(g) < hb_cnt)),
            .hb       (hb_val),
            .mode_i   (m_c[g]),
            .fill_i   (f_c[g]),
            .win_i    (w_c[g]),
            .id_i     (i_c[g]),
            .mode_o   (m_c[g+1]),
            .fill_o   (f_c[g+1]),
            .win_o    (w_c[g+1]),
            .id_o     (i_c[g+1]),
            .rep_o    (r_c[g]),
            .rep_id_o (ri_c[g])
         );
      end
   endgenerate

   always_comb begin
      rep_any = 1'b0;
      rep_id  = '0;
      for (int g = 0; g < MAX_GROUP; g++) begin
         if (r_c[g]) begin
            rep_any = 1'b1;
            rep_id  = ri_c[g];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= DEC_HUNT;
         fill_q   <= '0;
         win_q    <= '0;
         id_q     <= '0;
         id_valid <= 1'b0;
         id_value <= '0;
      end else begin
         id_valid <= rep_any;
         if (rep_any) id_value <= rep_id;
         if (hb_vld) begin
            mode_q <= m_c[MAX_GROUP];
            fill_q <= f_c[MAX_GROUP];
            win_q  <= w_c[MAX_GROUP];
            id_q   <= i_c[MAX_GROUP];
         end
      end
   end
endmodule

// File: rtl/fsk_id_demod.sv
module fsk_id_demod #(
   parameter int SMP_W     = 8,
   parameter int SLICE_LVL = 127,
   parameter int CNT_W     = 8,
   parameter int FUZZ_LIM  = 9,
   parameter int RUN_W     = 6,
   parameter int FAST_HB   = 6,
   parameter int SLOW_HB   = 5,
   parameter int MAX_GROUP = 4,
   parameter int ID_W      = 44
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   output logic             id_valid,
   output logic [ID_W-1:0]  id_value
);
   localparam int GRP_W = $clog2(MAX_GROUP + 1);

   generate
      if (SLICE_LVL < 1 || SLICE_LVL >= (1 << SMP_W)) begin : g_bad_lvl
         $error("SLICE_LVL out of sample range");
      end
      if (FUZZ_LIM < 2 || FUZZ_LIM >= (1 << CNT_W)) begin : g_bad_fuzz
         $error("FUZZ_LIM must fit the period counter");
      end
      if (FAST_HB < 1 || SLOW_HB < 1) begin : g_bad_div
         $error("half-bit divisors must be positive");
      end
      if (MAX_GROUP < 1 || MAX_GROUP > 7) begin : g_bad_grp
         $error("MAX_GROUP must lie in 1..7");
      end
      if ((1 << RUN_W) <= FAST_HB * MAX_GROUP) begin : g_bad_run
         $error("RUN_W too small for the largest group");
      end
      if (ID_W < 2) begin : g_bad_id
         $error("ID_W must be at least 2");
      end
   endgenerate

   logic             cls_vld;
   logic             cls_fast;
   logic             hb_vld;
   logic [GRP_W-1:0] hb_cnt;
   logic             hb_val;

   fskd_edge_period #(
      .SMP_W(SMP_W), .SLICE_LVL(SLICE_LVL), .CNT_W(CNT_W), .FUZZ_LIM(FUZZ_LIM)
   ) edge_i (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .cls_vld(cls_vld), .cls_fast(cls_fast)
   );

   fskd_run_group #(
      .RUN_W(RUN_W), .FAST_HB(FAST_HB), .SLOW_HB(SLOW_HB),
      .MAX_GROUP(MAX_GROUP), .GRP_W(GRP_W)
   ) run_i (
      .clk(clk), .rst_n(rst_n), .cls_vld(cls_vld), .cls_fast(cls_fast),
      .hb_vld(hb_vld), .hb_cnt(hb_cnt), .hb_val(hb_val)
   );

   fskd_frame_dec #(
      .ID_W(ID_W), .MAX_GROUP(MAX_GROUP), .GRP_W(GRP_W)
   ) dec_i (
      .clk(clk), .rst_n(rst_n), .hb_vld(hb_vld), .hb_cnt(hb_cnt),
      .hb_val(hb_val), .id_valid(id_valid), .id_value(id_value)
   );
endmodule

// File: rtl/fskd_chk.sv
module fskd_chk #(
   parameter int ID_W      = 44,
   parameter int GRP_W     = 3,
   parameter int MAX_GROUP = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             smp_valid,
   input logic             cls_vld,
   input logic             hb_vld,
   input logic [GRP_W-1:0] hb_cnt,
   input logic             id_valid,
   input logic [ID_W-1:0]  id_value
);
   // R6
   rpt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      id_valid |-> (id_value != '0));

   // R6
   rpt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      id_valid |=> !id_valid);

   // R10
   id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !id_valid |-> $stable(id_value));

   // R4
   grp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hb_vld |-> (hb_cnt != '0 && hb_cnt <= GRP_W'(MAX_GROUP)));

   // R9
   cls_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cls_vld |-> $past(smp_valid));
endmodule

bind fsk_id_demod fskd_chk #(
   .ID_W(ID_W), .GRP_W(GRP_W), .MAX_GROUP(MAX_GROUP)
) chk_i (
   .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .cls_vld(cls_vld),
   .hb_vld(hb_vld), .hb_cnt(hb_cnt), .id_valid(id_valid), .id_value(id_value)
);

// File: tb/fsk_id_demod_tb_top.sv
`timescale 1ns/1ps
module fsk_id_demod_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [7:0]  smp_data = 8'd0;
   logic        id_valid;
   logic [43:0] id_value;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   bit gap_on = 1'b0;
   bit jit_on = 1'b0;
   bit edge_on = 1'b0;

   logic [43:0] exp_q[$];
   string       tag_q[$];
   logic [43:0] obs_q[$];

   always #2 clk = ~clk;

   fsk_id_demod dut_i (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .id_valid(id_valid), .id_value(id_value)
   );

   always @(negedge clk) if (rst_n && id_valid) obs_q.push_back(id_value);

   task automatic check(bit ok, string rq, logic [43:0] act, logic [43:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", rq, act, exp);
      end
   endtask

   function automatic int fast_len();
      return jit_on ? int'($urandom_range(7, 8)) : 8;
   endfunction

   function automatic int slow_len();
      return jit_on ? int'($urandom_range(9, 11)) : 10;
   endfunction

   task automatic put_smp(logic [7:0] v);
      if (gap_on) begin
         int g = int'($urandom_range(0, 2));
         repeat (g) begin
            @(negedge clk);
            smp_valid = 1'b0;
            smp_data  = 8'($urandom());
         end
      end
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = v;
   endtask

   // one field cycle: a short high phase then a low phase
   task automatic send_period(int len);
      int hi_n = (len <= 8) ? 2 : 3;
      logic [7:0] hi_l = edge_on ? 8'd127 : 8'(127 + $urandom_range(0, 128));
      logic [7:0] lo_l = edge_on ? 8'd126 : 8'($urandom_range(0, 126));
      for (int j = 0; j < len; j++) put_smp((j < hi_n) ? hi_l : lo_l);
   endtask

   task automatic send_hb(bit v);
      if (v) repeat (6) send_period(fast_len());
      else   repeat (5) send_period(slow_len());
   endtask

   task automatic send_frame(logic [43:0] id, int bad);
      send_hb(1); send_hb(1); send_hb(1); send_hb(0);
      send_hb(0); send_hb(0); send_hb(1); send_hb(0);
      for (int i = 43; i >= 0; i--) begin
         if (i % 4 == 3) send_period(fast_len());
         if (i == bad) begin
            send_hb(1); send_hb(1);
         end else if (id[i]) begin
            send_hb(0); send_hb(1);
         end else begin
            send_hb(1); send_hb(0);
         end
      end
   endtask

   task automatic expect_id(logic [43:0] id, string tag);
      exp_q.push_back(id);
      tag_q.push_back(tag);
   endtask

   function automatic logic [43:0] rnd_id();
      logic [43:0] r = {12'($urandom()), 32'($urandom())};
      if (r == '0) r = 44'h1;
      return r;
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R6 actual no end expected end");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [43:0] id;
      void'($urandom(32'd2718));
      repeat (4) @(negedge clk);
      // R10 reset state
      check(id_valid == 1'b0, "R10 reset id_valid", 44'(id_valid), 44'h0);
      check(id_value == '0, "R10 reset id_value", id_value, 44'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 junk before lock, then a long slow run that rounds to nothing
      for (int j = 0; j < 20; j++) put_smp(8'($urandom()));
      repeat (30) send_period(10);

      id = 44'h123_4567_89AB;
      send_frame(id, -1); expect_id(id, "R2 first frame after junk");
      send_frame(44'h0, -1);                       // R7 zero id dropped
      id = 44'hFFF_FFFF_FFFF;
      send_frame(id, -1); expect_id(id, "R4 all ones, four half-bit run");
      id = 44'h000_0000_0001;
      send_frame(id, -1); expect_id(id, "R5 single low bit");
      send_frame(rnd_id(), 20);                    // R8 invalid pair
      edge_on = 1'b1;
      id = rnd_id();
      send_frame(id, -1); expect_id(id, "R1 levels 126/127");
      edge_on = 1'b0;
      jit_on = 1'b1;
      id = rnd_id();
      send_frame(id, -1); expect_id(id, "R3 jittered periods");
      jit_on = 1'b0;
      gap_on = 1'b1;
      id = rnd_id();
      send_frame(id, -1); expect_id(id, "R9 idle gaps");
      gap_on = 1'b0;
      for (int k = 0; k < 4; k++) begin
         jit_on = bit'($urandom_range(0, 1));
         id = rnd_id();
         send_frame(id, -1); expect_id(id, "R6 random frame");
      end
      jit_on = 1'b0;
      send_frame(rnd_id(), -1);                    // trailer, never reported
      repeat (12) send_period(8);
      @(negedge clk);
      smp_valid = 1'b0;
      repeat (20) @(negedge clk);

      check(obs_q.size() == exp_q.size(), "R6 R7 R8 report count",
            44'(obs_q.size()), 44'(exp_q.size()));
      for (int i = 0; i < exp_q.size(); i++) begin
         if (i < obs_q.size()) check(obs_q[i] == exp_q[i], tag_q[i], obs_q[i], exp_q[i]);
         else                  check(1'b0, tag_q[i], 44'h0, exp_q[i]);
      end
      if (obs_q.size() > 0)
         check(id_value == obs_q[obs_q.size()-1], "R10 hold last id",
               id_value, obs_q[obs_q.size()-1]);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule